// File: doc/BRIEF.md
# Timed Pin Controller: Periodic Output and Edge Capture

This block serves four general-purpose timing pins that run off a shared time-of-day counter. The counter is outside the block and arrives as a seconds value and a nanoseconds value. The counter advances by a fixed number of nanoseconds on every clock. Each pin has a two-bit action field, a sync flag and two nanosecond duration fields. The action selects one of three behaviours: idle, waveform output or edge capture.

In waveform action with sync clear, the pin free-runs. It is high for the first duration and low for the second, over and over. In waveform action with sync set, it produces a pulse-per-second. The output rises when the time of day passes a phase offset within the second, and that offset is held in the low-duration field. The output then stays high for the high duration and stays low until the next second.

In capture action with sync set, the pin input is synchronised, and a rising edge latches the current time of day. The edge also sets a per-pin status bit. Status bits are cleared by writing 1 to them. The enabled status bits are combined into a single interrupt line.

Top module: `tod_pin_ctrl`

## Requirements
- R1: After reset every wave output is low, every status bit is 0, irq_o is low, and every captured seconds and nanoseconds value is 0.
- R2: With action 1 (waveform) and sync 0, the output goes high on the first clock that sees the action. It then alternates between max(1, ceil(H/NS_PER_CLK)) clocks high and max(1, ceil(L/NS_PER_CLK)) clocks low, where H and L are the high and low fields.
- R3: A high field of 0 stands for DEF_HIGH_NS (5000 ns) in both waveform modes.
- R4: Any action other than 1 drives the wave output low from the next clock on.
- R5: With action 1 and sync 1, the output rises on the clock whose sampled time-of-day nanoseconds N satisfies L <= N < L + NS_PER_CLK, where L is the phase held in the low field. It stays high for the R2 high count of clocks and stays low otherwise.
- R6: With action 2 (capture) and sync 1, the pin input passes through two flip-flops. A rising edge latches the time of day present at the third clock after the input change, and sets the status bit of that pin.
- R7: Falling edges cause no capture. Edges cause no capture when the action is not 2 or sync is 0.
- R8: While the status bit of a pin is set, further edges on that pin leave its captured time unchanged.
- R9: A 1 in bit p of irq_clr_i clears status bit p on the next clock. Zero bits leave the other pins' status unchanged.
- R10: irq_o is high when any pin has both its status bit and its enable bit set. A masked pin still sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tod_sec_i | input | SEC_W | Time-of-day seconds |
| tod_ns_i | input | NS_W | Time-of-day nanoseconds |
| act_i | input | 2*NPIN | Per-pin action: 0 idle, 1 waveform, 2 capture |
| sync_i | input | NPIN | Per-pin sync flag |
| high_ns_i | input | NS_W*NPIN | Per-pin high duration in ns |
| low_ns_i | input | NS_W*NPIN | Per-pin low duration, or phase offset in sync mode |
| wave_o | output | NPIN | Waveform outputs |
| pin_i | input | NPIN | Asynchronous capture inputs |
| irq_en_i | input | NPIN | Per-pin interrupt enable |
| irq_clr_i | input | NPIN | Write-1-to-clear strobe for the status bits |
| irq_sts_o | output | NPIN | Status bits |
| irq_o | output | 1 | Combined interrupt |
| cap_sec_o | output | SEC_W*NPIN | Captured seconds per pin |
| cap_ns_o | output | NS_W*NPIN | Captured nanoseconds per pin |

## Verification
The bench sweeps free-running duration pairs on every pin. The sweep includes durations that are not multiples of the clock step, a zero low time and a zero high time; an off-by-one in the duration count would shift every edge of the pattern. Pulse-per-second runs cross the nanosecond wrap with a zero phase, a phase that is a multiple of the clock step and a phase that is not. A trigger window that is too wide or misaligned would give a double or early rise. Capture is checked for the exact latency of the synchroniser and for seconds latched across a wrap. It is also checked that a second edge cannot overwrite the held time, that falling edges and the wrong mode are ignored, and that clearing one status bit leaves the others set.

// File: rtl/tod_pin_pkg.sv
package tod_pin_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_WAVE  = 2'd1,
    ACT_STAMP = 2'd2
  } pin_act_e;
endpackage

// File: rtl/tod_pin_wave.sv
module tod_pin_wave
  import tod_pin_pkg::*;
#(
  parameter int NS_W        = 30,
  parameter int NS_PER_CLK  = 8,
  parameter int DEF_HIGH_NS = 5000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      act_i,
  input  logic            sync_i,
  input  logic [NS_W-1:0] high_ns_i,
  input  logic [NS_W-1:0] low_ns_i,
  input  logic [NS_W-1:0] tod_ns_i,
  output logic            wave_o
);
  localparam int CW = NS_W + 1;

  logic            level_q, run_q;
  logic [CW-1:0]   cnt_q, cnt_nxt;
  logic [NS_W-1:0] high_eff, cur_len, ofs;
  logic            on, expire, trig;

  always_comb begin
    on       = (act_i == ACT_WAVE);
    high_eff = (high_ns_i == '0) ? NS_W'(DEF_HIGH_NS) : high_ns_i;
    cur_len  = level_q ? high_eff : low_ns_i;
    cnt_nxt  = cnt_q + CW'(NS_PER_CLK);
    expire   = (cnt_nxt >= {1'b0, cur_len});
    // sync mode: low field is the phase inside the second
    ofs      = tod_ns_i - low_ns_i;
    trig     = (tod_ns_i >= low_ns_i) && (ofs < NS_W'(NS_PER_CLK));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (!on) begin
      level_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (sync_i) begin
      run_q <= 1'b0;
      if (trig) begin
        level_q <= 1'b1;
        cnt_q   <= '0;
      end else if (level_q && expire) begin
        level_q <= 1'b0;
        cnt_q   <= '0;
      end else if (level_q) begin
        cnt_q <= cnt_nxt;
      end
    end else if (!run_q) begin
      run_q   <= 1'b1;
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (expire) begin
      level_q <= ~level_q;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  assign wave_o = level_q;

  // R4
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i != ACT_WAVE) |=> !wave_o);

  // R5
  sync_no_early_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && sync_i && !trig && !level_q) |=> !wave_o);
endmodule

// File: rtl/tod_pin_stamp.sv
module tod_pin_stamp
  import tod_pin_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       act_i,
  input  logic             sync_i,
  input  logic             pin_i,
  input  logic             clr_i,
  input  logic [SEC_W-1:0] tod_sec_i,
  input  logic [NS_W-1:0]  tod_ns_i,
  output logic             sts_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o
);
  logic             s1_q, s2_q, s3_q;
  logic             rise, arm, take, sts_q;
  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    rise = s2_q & ~s3_q;
    arm  = (act_i == ACT_STAMP) && sync_i;
    take = rise && arm && !sts_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
      sec_q <= '0;
      ns_q  <= '0;
    end else if (take) begin
      sts_q <= 1'b1;
      sec_q <= tod_sec_i;
      ns_q  <= tod_ns_i;
    end else if (clr_i) begin
      sts_q <= 1'b0;
    end
  end

  assign sts_o = sts_q;
  assign sec_o = sec_q;
  assign ns_o  = ns_q;

  // R8
  hold_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !clr_i) |=> (sts_q && $stable(sec_q) && $stable(ns_q)));

  // R6
  set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q) |-> $past(arm && rise));

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && sts_q) |=> !sts_q);
endmodule

// File: rtl/tod_pin_ctrl.sv
module tod_pin_ctrl
  import tod_pin_pkg::*;
#(
  parameter int NPIN        = 4,
  parameter int SEC_W       = 32,
  parameter int NS_W        = 30,
  parameter int NS_PER_CLK  = 8,
  parameter int DEF_HIGH_NS = 5000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SEC_W-1:0]      tod_sec_i,
  input  logic [NS_W-1:0]       tod_ns_i,
  input  logic [2*NPIN-1:0]     act_i,
  input  logic [NPIN-1:0]       sync_i,
  input  logic [NS_W*NPIN-1:0]  high_ns_i,
  input  logic [NS_W*NPIN-1:0]  low_ns_i,
  output logic [NPIN-1:0]       wave_o,
  input  logic [NPIN-1:0]       pin_i,
  input  logic [NPIN-1:0]       irq_en_i,
  input  logic [NPIN-1:0]       irq_clr_i,
  output logic [NPIN-1:0]       irq_sts_o,
  output logic                  irq_o,
  output logic [SEC_W*NPIN-1:0] cap_sec_o,
  output logic [NS_W*NPIN-1:0]  cap_ns_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    tod_pin_wave #(
      .NS_W(NS_W), .NS_PER_CLK(NS_PER_CLK), .DEF_HIGH_NS(DEF_HIGH_NS)
    ) u_wave (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_i[2*p +: 2]),
      .sync_i   (sync_i[p]),
      .high_ns_i(high_ns_i[NS_W*p +: NS_W]),
      .low_ns_i (low_ns_i[NS_W*p +: NS_W]),
      .tod_ns_i (tod_ns_i),
      .wave_o   (wave_o[p])
    );

    tod_pin_stamp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_stamp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_i[2*p +: 2]),
      .sync_i   (sync_i[p]),
      .pin_i    (pin_i[p]),
      .clr_i    (irq_clr_i[p]),
      .tod_sec_i(tod_sec_i),
      .tod_ns_i (tod_ns_i),
      .sts_o    (irq_sts_o[p]),
      .sec_o    (cap_sec_o[SEC_W*p +: SEC_W]),
      .ns_o     (cap_ns_o[NS_W*p +: NS_W])
    );
  end

  assign irq_o = |(irq_sts_o & irq_en_i);

  // R10
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);
endmodule

// File: tb/tod_pin_ctrl_test.sv
module tod_pin_ctrl_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  NPIN = 4, SEC_W = 32, NS_W = 30, INC = 8, DEF_H = 5000;
  localparam longint SEC_NS = 1000000000;

  logic clk = 0, rst_n = 0;
  logic [SEC_W-1:0] tod_sec = 32'd100;
  logic [NS_W-1:0]  tod_ns = '0;
  logic [2*NPIN-1:0] act = '0;
  logic [NPIN-1:0] sync = '0, pin = '0, en = '0, clr = '0;
  logic [NS_W*NPIN-1:0] hi = '0, lo = '0;
  logic [NPIN-1:0] wave, sts;
  logic irq;
  logic [SEC_W*NPIN-1:0] csec;
  logic [NS_W*NPIN-1:0]  cns;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int chk_kind = 0, wpin = 0, k = 0, hc = 1, lc = 1, since = 1000000;
  longint phase = 0;

  tod_pin_ctrl #(.NPIN(NPIN), .SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_CLK(INC),
                 .DEF_HIGH_NS(DEF_H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tod_sec_i(tod_sec), .tod_ns_i(tod_ns),
    .act_i(act), .sync_i(sync), .high_ns_i(hi), .low_ns_i(lo), .wave_o(wave),
    .pin_i(pin), .irq_en_i(en), .irq_clr_i(clr), .irq_sts_o(sts), .irq_o(irq),
    .cap_sec_o(csec), .cap_ns_o(cns));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, longint actv, longint expv);
    nchk++;
    if (actv != expv) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, actv, expv);
    end
  endtask

  function automatic int ncyc(longint d);
    return (d == 0) ? 1 : int'((d + INC - 1) / INC);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  endtask

  // time-of-day source plus per-cycle waveform model
  initial forever begin
    @(negedge clk);
    if (chk_kind == 1) begin
      check("R2 free-run", wave[wpin], ((k % (hc + lc)) < hc) ? 1 : 0);
      k++;
    end else if (chk_kind == 2) begin
      if (longint'(tod_ns) >= phase && longint'(tod_ns) - phase < INC) since = 0;
      else if (since < 1000000) since++;
      check("R5 pps", wave[wpin], (since < hc) ? 1 : 0);
    end
    if (longint'(tod_ns) + INC >= SEC_NS) begin
      tod_ns = NS_W'(longint'(tod_ns) + INC - SEC_NS);
      tod_sec = tod_sec + 1;
    end else tod_ns = tod_ns + NS_W'(INC);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic free_run(int p, longint h, longint l);
    longint he;
    he = (h == 0) ? DEF_H : h;
    hi[NS_W*p +: NS_W] = NS_W'(h);
    lo[NS_W*p +: NS_W] = NS_W'(l);
    sync[p] = 0;
    hc = ncyc(he); lc = ncyc(l); k = 0; wpin = p;
    act[2*p +: 2] = 2'd1;
    chk_kind = 1;
    step(3 * (hc + lc) + 1);
    act[2*p +: 2] = 2'd0;
    chk_kind = 0;
    step(2);
    check("R4 idle low", wave[p], 0);
  endtask

  task automatic pps(int p, longint h, longint ph);
    longint he;
    he = (h == 0) ? DEF_H : h;
    tod_ns = NS_W'(SEC_NS - 50 * INC);
    hi[NS_W*p +: NS_W] = NS_W'(h);
    lo[NS_W*p +: NS_W] = NS_W'(ph);
    phase = ph; hc = ncyc(he); since = 1000000; wpin = p;
    sync[p] = 1;
    act[2*p +: 2] = 2'd1;
    chk_kind = 2;
    step(150 + hc);
    act[2*p +: 2] = 2'd0;
    sync[p] = 0;
    chk_kind = 0;
    step(2);
    check("R4 idle after pps", wave[p], 0);
  endtask

  // raise pin p, return expected latched time
  task automatic edge_up(int p, output longint es, output longint en_ns);
    es = tod_sec; en_ns = tod_ns;
    for (int i = 0; i < 2; i++) begin
      en_ns += INC;
      if (en_ns >= SEC_NS) begin en_ns -= SEC_NS; es++; end
    end
    pin[p] = 1;
    step(4);
  endtask

  task automatic clear(logic [NPIN-1:0] m);
    clr = m;
    step(1);
    clr = '0;
  endtask

  initial begin
    longint es, ens, es2, ens2;
    step(3);
    rst_n = 1;
    step(1);
    check("R1 wave", wave, 0);
    check("R1 status", sts, 0);
    check("R1 irq", irq, 0);
    check("R1 cap sec", csec, 0);
    check("R1 cap ns", cns, 0);

    for (int p = 0; p < NPIN; p++) begin
      free_run(p, 16, 16);
      free_run(p, 20, 36);
      free_run(p, 13, 29);
      free_run(p, 8, 0);
    end
    free_run(2, 0, 40);            // R3 default high time

    pps(0, 24, 0);
    pps(1, 24, 320);
    pps(3, 40, 322);
    pps(2, 0, 64);                 // R3 default high time in sync mode

    for (int p = 0; p < NPIN; p++) begin
      act[2*p +: 2] = 2'd2; sync[p] = 1; en[p] = 1;
      if (p == 3) tod_ns = NS_W'(SEC_NS - INC);
      edge_up(p, es, ens);
      check("R6 status set", sts[p], 1);
      check("R10 irq", irq, 1);
      check("R6 cap sec", csec[SEC_W*p +: SEC_W], es);
      check("R6 cap ns", cns[NS_W*p +: NS_W], ens);
      pin[p] = 0; step(4);
      edge_up(p, es2, ens2);
      check("R8 held sec", csec[SEC_W*p +: SEC_W], es);
      check("R8 held ns", cns[NS_W*p +: NS_W], ens);
      pin[p] = 0; step(4);
      clear(NPIN'(1) << p);
      check("R9 cleared", sts[p], 0);
      check("R9 irq low", irq, 0);
      edge_up(p, es2, ens2);
      check("R6 recapture ns", cns[NS_W*p +: NS_W], ens2);
      check("R6 recapture sec", csec[SEC_W*p +: SEC_W], es2);
      clear(NPIN'(1) << p);
      pin[p] = 0; step(5);         // R7 falling edge
      check("R7 falling edge", sts[p], 0);
    end

    // R7 wrong mode
    sync[0] = 0; edge_up(0, es, ens); pin[0] = 0; step(4);
    check("R7 sync off", sts[0], 0);
    sync[1] = 1; act[3:2] = 2'd0; edge_up(1, es, ens); pin[1] = 0; step(4);
    check("R7 idle action", sts[1], 0);
    act[3:2] = 2'd2;

    // R10 mask, R9 selective clear
    en = 4'b0100;
    edge_up(1, es, ens); edge_up(2, es2, ens2);
    check("R10 masked still sets", sts[1], 1);
    check("R10 enabled irq", irq, 1);
    clear(4'b0100);
    check("R10 masked irq low", irq, 0);
    check("R9 other kept", sts, 4'b0010);
    check("R8 kept ns pin1", cns[NS_W*1 +: NS_W], ens);
    pin = '0; step(4);

    summary();
  end
endmodule